// File: doc/BRIEF.md
# Interrupt Vector Ring Producer

This block gathers interrupt events from on-chip sources and stores each one as a 16-byte record in a circular buffer that lives in memory. A host consumer drains the buffer and reports its progress by moving a read pointer. The block owns the write pointer and asserts an interrupt line while the buffer holds records the host has not yet read. When the host falls behind, the oldest record is overwritten and a sticky overflow flag is raised. The host can later recover by restarting at the write pointer plus 16.

Software sets the block up through a small register file. The registers hold the enable bits, the ring size, the base address, the write-pointer mirror address and the read pointer. The read pointer can also arrive on a doorbell-style write port. Events enter through a valid/ready port and wait in a small FIFO. Records leave as single 32-bit memory writes under a valid/ready handshake. After each record the block can optionally write the new write-pointer value to a second memory address.

Top module: `intr_ring_writer`

## Requirements
- R1: Pointers count bytes. Each record advances the write pointer by 16, modulo the ring byte size. The ring byte size is 4·2^S, where S is the ring-size field CTRL[12:8] and gives the ring length in 32-bit words. The pointer mask is the ring byte size minus one.
- R2: A record is four memory writes in order, at addresses ({BASE,8'h00} + wptr + 0/4/8/12), where BASE is a 32-bit register holding address bits [39:8]. The four words are:
  - word 0: {24'b0, source id}
  - word 1: {4'b0, 28-bit source data}
  - word 2: {16-bit address-space id, 8-bit VM id, 8-bit ring id}
  - word 3: zero
- R3: irq is 1 exactly when CTRL[0] (ring on) and CTRL[1] (irq on) are both 1 and either the read and write pointers differ or the overflow flag is set.
- R4: An event taken while CTRL[0] or CTRL[1] is 0 is discarded. It produces no memory write and leaves the write pointer unchanged.
- R5: While CTRL[0] is 0, both the read and the write pointer are held at zero.
- R6: If (wptr+16) masked equals the read pointer when a record's last word is accepted, the record still lands, the write pointer still advances, and the overflow flag is set. The flag reads as bit 0 of the WPTR register (offset 3). WPTR returns {pointer} | flag.
- R7: While CTRL[2] (overflow clear) is 1, the overflow flag is held at 0 and overflows are not recorded. Once CTRL[2] returns to 0, a new overflow sets the flag again.
- R8: The read pointer takes the low pointer bits of the new value, ANDed with the mask, with bits [3:0] forced to zero. The source depends on CTRL[4]:
  - CTRL[4]=0: taken from a register write to RPTR (offset 2); doorbell writes are ignored.
  - CTRL[4]=1: taken from a doorbell write; RPTR register writes are ignored.
- R9: With CTRL[3] (writeback) set, each record is followed by one write of the WPTR register value to address {WBHI[7:0], WBLO}. WBLO is at offset 4 and WBHI at offset 5; only 8 bits of WBHI are kept.
- R10: While mem_valid is high and mem_ready is low, the address and data hold. Records are written in event arrival order. evt_ready drops when the FIFO is full.
- R11: Register offsets are CTRL 0, BASE 1, RPTR 2, WPTR 3, WBLO 4, WBHI 5. All registers read back through reg_rdata. Reset leaves every register, both pointers and irq at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Event present |
| evt_ready | output | 1 | Event FIFO has room |
| evt_src | input | 8 | Source id |
| evt_data | input | 28 | Source data |
| evt_ring | input | 8 | Ring id |
| evt_vmid | input | 8 | VM id |
| evt_pasid | input | 16 | Address-space id |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| db_valid | input | 1 | Doorbell read-pointer write |
| db_data | input | 32 | Doorbell byte offset |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory write accepted |
| mem_addr | output | 40 | Memory byte address |
| mem_data | output | 32 | Memory write data |
| irq | output | 1 | Unread records pending |

## Verification
The bench builds the block with a 10-bit pointer and a two-entry event FIFO.

The shallow FIFO makes a four-event burst under memory back-pressure push evt_ready low. With rings of 64 and 32 bytes, wrap-around and overflow occur within a handful of events. Overflow is reached both with the clear bit held and after it drops.

A software model of the pointers predicts every memory write and every register read. These predictions cover both read-pointer paths and the writeback word carrying the overflow flag.

// File: rtl/intr_ring_pkg.sv
package intr_ring_pkg;

  localparam int VEC_BYTES = 16;
  localparam int SIZE_LSB  = 8;
  localparam int SIZE_W    = 5;

  localparam int CB_RING = 0;
  localparam int CB_IRQ  = 1;
  localparam int CB_CLR  = 2;
  localparam int CB_WB   = 3;
  localparam int CB_DB   = 4;
  localparam logic [31:0] CTRL_KEEP = 32'h0000_1F1F;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_BASE = 3'd1;
  localparam logic [2:0] RA_RPTR = 3'd2;
  localparam logic [2:0] RA_WPTR = 3'd3;
  localparam logic [2:0] RA_WBLO = 3'd4;
  localparam logic [2:0] RA_WBHI = 3'd5;

  typedef struct packed {
    logic [15:0] pasid;
    logic [7:0]  vmid;
    logic [7:0]  ring;
    logic [27:0] data;
    logic [7:0]  src;
  } intr_evt_t;

  typedef enum logic [2:0] {
    WS_IDLE, WS_W0, WS_W1, WS_W2, WS_W3, WS_WB
  } wr_state_e;

endpackage

// File: rtl/intr_evt_fifo.sv
module intr_evt_fifo #(
  parameter int WIDTH = 68,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  output logic             full,
  input  logic             pop,
  output logic             empty,
  output logic [WIDTH-1:0] dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store_q [DEPTH];
  logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    full    = (cnt_q == CW'(DEPTH));
    empty   = (cnt_q == '0);
    do_push = push & ~full;
    do_pop  = pop & ~empty;
    wr_d    = do_push ? bump(wr_q) : wr_q;
    rd_d    = do_pop ? bump(rd_q) : rd_q;
    cnt_d   = cnt_q + CW'(do_push) - CW'(do_pop);
    dout    = store_q[rd_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store_q[wr_q] <= din;
  end

  // R10: a full FIFO that is not drained stays full (no overrun)
  p_fifo_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);

endmodule

// File: rtl/intr_ring_regs.sv
module intr_ring_regs
  import intr_ring_pkg::*;
#(
  parameter int PTR_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             db_valid,
  input  logic [31:0]      db_data,
  input  logic [PTR_W-1:0] wptr,
  input  logic             ovf_flag,
  output logic             ring_on,
  output logic             irq_on,
  output logic             ovf_clr,
  output logic             wb_on,
  output logic [PTR_W-1:0] ring_mask,
  output logic [PTR_W-1:0] rptr,
  output logic [31:0]      base_hi,
  output logic [39:0]      wb_addr
);
  localparam logic [PTR_W-1:0] SLOT_ALIGN = ~PTR_W'(VEC_BYTES - 1);

  logic [31:0]       ctrl_q, ctrl_d, base_q, base_d, wblo_q, wblo_d;
  logic [7:0]        wbhi_q, wbhi_d;
  logic [PTR_W-1:0]  rptr_q, rptr_d;
  logic              db_sel, reg_rptr_wr;
  logic [SIZE_W-1:0] size_log2;
  logic              unused_db;

  assign unused_db = ^db_data[31:PTR_W];

  always_comb begin
    ring_on   = ctrl_q[CB_RING];
    irq_on    = ctrl_q[CB_IRQ];
    ovf_clr   = ctrl_q[CB_CLR];
    wb_on     = ctrl_q[CB_WB];
    db_sel    = ctrl_q[CB_DB];
    size_log2 = ctrl_q[SIZE_LSB +: SIZE_W];
    ring_mask = '0;
    for (int i = 0; i < PTR_W; i++) begin
      ring_mask[i] = (i < (int'(size_log2) + 2));
    end
    rptr    = rptr_q;
    base_hi = base_q;
    wb_addr = {wbhi_q, wblo_q};
  end

  always_comb begin
    ctrl_d = ctrl_q;
    base_d = base_q;
    wblo_d = wblo_q;
    wbhi_d = wbhi_q;
    reg_rptr_wr = reg_we && (reg_addr == RA_RPTR);
    if (reg_we) begin
      case (reg_addr)
        RA_CTRL: ctrl_d = reg_wdata & CTRL_KEEP;
        RA_BASE: base_d = reg_wdata;
        RA_WBLO: wblo_d = reg_wdata;
        RA_WBHI: wbhi_d = reg_wdata[7:0];
        default: ;
      endcase
    end
    if (!ring_on)
      rptr_d = '0;
    else if (!db_sel && reg_rptr_wr)
      rptr_d = reg_wdata[PTR_W-1:0] & ring_mask & SLOT_ALIGN;
    else if (db_sel && db_valid)
      rptr_d = db_data[PTR_W-1:0] & ring_mask & SLOT_ALIGN;
    else
      rptr_d = rptr_q;
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL: reg_rdata = ctrl_q;
      RA_BASE: reg_rdata = base_q;
      RA_RPTR: reg_rdata = 32'(rptr_q);
      RA_WPTR: reg_rdata = 32'(wptr) | 32'(ovf_flag);
      RA_WBLO: reg_rdata = wblo_q;
      RA_WBHI: reg_rdata = {24'h0, wbhi_q};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      base_q <= '0;
      wblo_q <= '0;
      wbhi_q <= '0;
      rptr_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      base_q <= base_d;
      wblo_q <= wblo_d;
      wbhi_q <= wbhi_d;
      rptr_q <= rptr_d;
    end
  end

  // R8: doorbell writes have no effect while the register path is selected
  p_db_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!db_sel && db_valid && !reg_rptr_wr) |=> $stable(rptr_q));

  // R8: register writes to the read pointer have no effect while the doorbell path is selected
  p_reg_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (db_sel && reg_rptr_wr && !db_valid) |=> $stable(rptr_q));

endmodule

// File: rtl/intr_vec_writer.sv
module intr_vec_writer
  import intr_ring_pkg::*;
#(
  parameter int PTR_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_avail,
  input  intr_evt_t        evt_in,
  output logic             evt_pop,
  input  logic             ring_on,
  input  logic             irq_on,
  input  logic             ovf_clr,
  input  logic             wb_on,
  input  logic [PTR_W-1:0] ring_mask,
  input  logic [PTR_W-1:0] rptr,
  input  logic [31:0]      base_hi,
  input  logic [39:0]      wb_addr,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [39:0]      mem_addr,
  output logic [31:0]      mem_data,
  output logic [PTR_W-1:0] wptr,
  output logic             ovf_flag
);
  localparam logic [PTR_W-1:0] STEP = PTR_W'(VEC_BYTES);

  wr_state_e        st_q, st_d;
  intr_evt_t        cur_q, cur_d;
  logic [39:0]      addr_q, addr_d;
  logic [31:0]      wbw_q, wbw_d;
  logic [PTR_W-1:0] wptr_q, wptr_d, next_ptr;
  logic             ovf_q, ovf_d;
  logic             active, take, load_evt, commit, wrap_full;
  logic [1:0]       word_idx;

  always_comb begin
    active    = ring_on & irq_on;
    take      = (st_q == WS_IDLE) & evt_avail;
    evt_pop   = take;
    load_evt  = take & active;
    commit    = (st_q == WS_W3) & mem_ready;
    next_ptr  = (wptr_q + STEP) & ring_mask;
    wrap_full = (next_ptr == rptr);

    st_d   = st_q;
    cur_d  = cur_q;
    addr_d = addr_q;
    wbw_d  = wbw_q;
    case (st_q)
      WS_IDLE: if (load_evt) begin
        st_d   = WS_W0;
        cur_d  = evt_in;
        addr_d = {base_hi, 8'h00} + 40'(wptr_q);
      end
      WS_W0: if (mem_ready) st_d = WS_W1;
      WS_W1: if (mem_ready) st_d = WS_W2;
      WS_W2: if (mem_ready) st_d = WS_W3;
      WS_W3: if (mem_ready) begin
        st_d   = wb_on ? WS_WB : WS_IDLE;
        addr_d = wb_addr;
      end
      WS_WB: if (mem_ready) st_d = WS_IDLE;
      default: st_d = WS_IDLE;
    endcase

    if (!ring_on)    wptr_d = '0;
    else if (commit) wptr_d = next_ptr;
    else             wptr_d = wptr_q;

    if (ovf_clr)                  ovf_d = 1'b0;
    else if (commit && wrap_full) ovf_d = 1'b1;
    else                          ovf_d = ovf_q;

    if (commit) wbw_d = 32'(wptr_d) | 32'(ovf_d);
  end

  always_comb begin
    mem_valid = (st_q != WS_IDLE);
    word_idx  = 2'd0;
    mem_data  = '0;
    case (st_q)
      WS_W0: begin word_idx = 2'd0; mem_data = {24'h0, cur_q.src}; end
      WS_W1: begin word_idx = 2'd1; mem_data = {4'h0, cur_q.data}; end
      WS_W2: begin word_idx = 2'd2; mem_data = {cur_q.pasid, cur_q.vmid, cur_q.ring}; end
      WS_W3: begin word_idx = 2'd3; mem_data = '0; end
      WS_WB: begin word_idx = 2'd0; mem_data = wbw_q; end
      default: ;
    endcase
    mem_addr = addr_q + 40'({word_idx, 2'b00});
    wptr     = wptr_q;
    ovf_flag = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WS_IDLE;
      cur_q  <= '0;
      addr_q <= '0;
      wbw_q  <= '0;
      wptr_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      addr_q <= addr_d;
      wbw_q  <= wbw_d;
      wptr_q <= wptr_d;
      ovf_q  <= ovf_d;
    end
  end

  // R10: a stalled write keeps its address and data
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  // R1: the write pointer stays on a 16-byte record boundary
  p_wptr_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_q[3:0] == 4'h0);

  // R1: while the ring stays on, the write pointer only moves by one record modulo the ring
  p_wptr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((wptr_q != $past(wptr_q)) && $past(ring_on))
      |-> (wptr_q == (($past(wptr_q) + STEP) & $past(ring_mask))));

  // R7: the clear bit forces the overflow flag low on the next cycle
  p_ovf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr |=> !ovf_q);

endmodule

// File: rtl/intr_ring_writer.sv
module intr_ring_writer
  import intr_ring_pkg::*;
#(
  parameter int PTR_W      = 18,
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evt_valid,
  output logic        evt_ready,
  input  logic [7:0]  evt_src,
  input  logic [27:0] evt_data,
  input  logic [7:0]  evt_ring,
  input  logic [7:0]  evt_vmid,
  input  logic [15:0] evt_pasid,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        db_valid,
  input  logic [31:0] db_data,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic [39:0] mem_addr,
  output logic [31:0] mem_data,
  output logic        irq
);
  localparam int EVT_W = $bits(intr_evt_t);

  intr_evt_t        evt_word, fifo_out;
  logic             fifo_full, fifo_empty, fifo_pop;
  logic             ring_on, irq_on, ovf_clr, wb_on, ovf_flag;
  logic [PTR_W-1:0] ring_mask, rptr, wptr;
  logic [31:0]      base_hi;
  logic [39:0]      wb_addr;

  always_comb begin
    evt_word.pasid = evt_pasid;
    evt_word.vmid  = evt_vmid;
    evt_word.ring  = evt_ring;
    evt_word.data  = evt_data;
    evt_word.src   = evt_src;
    evt_ready      = ~fifo_full;
    irq            = ring_on & irq_on & ((rptr != wptr) | ovf_flag);
  end

  intr_evt_fifo #(.WIDTH(EVT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (evt_valid),
    .din   (evt_word),
    .full  (fifo_full),
    .pop   (fifo_pop),
    .empty (fifo_empty),
    .dout  (fifo_out)
  );

  intr_ring_regs #(.PTR_W(PTR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .db_valid  (db_valid),
    .db_data   (db_data),
    .wptr      (wptr),
    .ovf_flag  (ovf_flag),
    .ring_on   (ring_on),
    .irq_on    (irq_on),
    .ovf_clr   (ovf_clr),
    .wb_on     (wb_on),
    .ring_mask (ring_mask),
    .rptr      (rptr),
    .base_hi   (base_hi),
    .wb_addr   (wb_addr)
  );

  intr_vec_writer #(.PTR_W(PTR_W)) u_writer (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_avail (~fifo_empty),
    .evt_in    (fifo_out),
    .evt_pop   (fifo_pop),
    .ring_on   (ring_on),
    .irq_on    (irq_on),
    .ovf_clr   (ovf_clr),
    .wb_on     (wb_on),
    .ring_mask (ring_mask),
    .rptr      (rptr),
    .base_hi   (base_hi),
    .wb_addr   (wb_addr),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .wptr      (wptr),
    .ovf_flag  (ovf_flag)
  );

  // R5: a disabled ring holds both pointers at zero
  p_disable_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ring_on |=> ((wptr == '0) && (rptr == '0)));

endmodule

// File: tb/intr_ring_writer_tb.sv
`timescale 1ns/1ps
module intr_ring_writer_tb;
  localparam int PTR_W      = 10;
  localparam int FIFO_DEPTH = 2;

  logic        clk, rst_n;
  logic        evt_valid, evt_ready;
  logic [7:0]  evt_src, evt_ring, evt_vmid;
  logic [27:0] evt_data;
  logic [15:0] evt_pasid;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        db_valid;
  logic [31:0] db_data;
  logic        mem_valid, mem_ready;
  logic [39:0] mem_addr;
  logic [31:0] mem_data;
  logic        irq;

  intr_ring_writer #(.PTR_W(PTR_W), .FIFO_DEPTH(FIFO_DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_src(evt_src), .evt_data(evt_data), .evt_ring(evt_ring),
    .evt_vmid(evt_vmid), .evt_pasid(evt_pasid),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .db_valid(db_valid), .db_data(db_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int stalls = 0;
  bit stall_mode = 1'b0;
  logic [71:0] exp_q [$];

  // bench model of the ring state
  logic [31:0]      m_base;
  logic [39:0]      m_wb;
  logic             m_wb_on, m_clr, m_active, m_ring;
  int               m_size;
  logic [PTR_W-1:0] m_w, m_r;
  logic             m_ovf;

  function automatic logic [PTR_W-1:0] m_mask();
    return PTR_W'((4 << m_size) - 1);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    mem_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
      #1;
      if (mem_valid && mem_ready) begin
        if (exp_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R4/R10 unexpected write: actual %h:%h expected none", mem_addr, mem_data);
        end else begin
          logic [71:0] it;
          it = exp_q.pop_front();
          check("R2/R9 write address", 64'(mem_addr), 64'(it[71:32]));
          check("R2/R9 write data", 64'(mem_data), 64'(it[31:0]));
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #2 d = reg_rdata;
  endtask

  task automatic set_ctrl(input bit ring, input bit ien, input bit clr, input bit wb,
                          input bit db, input int size);
    reg_wr(3'd0, {19'h0, 5'(size), 3'b000, db, wb, clr, ien, ring});
    m_ring = ring; m_size = size; m_clr = clr; m_wb_on = wb; m_active = ring && ien;
    if (!ring) begin m_w = '0; m_r = '0; end
    if (clr) m_ovf = 1'b0;
  endtask

  task automatic send(input logic [7:0] s, input logic [27:0] d, input logic [7:0] rg,
                      input logic [7:0] vm, input logic [15:0] pa);
    bit rdy;
    if (m_active) begin
      logic [39:0]      slot;
      logic [PTR_W-1:0] nxt;
      slot = {m_base, 8'h00} + 40'(m_w);
      exp_q.push_back({slot,          {24'h0, s}});
      exp_q.push_back({slot + 40'd4,  {4'h0, d}});
      exp_q.push_back({slot + 40'd8,  {pa, vm, rg}});
      exp_q.push_back({slot + 40'd12, 32'h0});
      nxt = (m_w + PTR_W'(16)) & m_mask();
      if (nxt == m_r && !m_clr) m_ovf = 1'b1;
      m_w = nxt;
      if (m_wb_on) exp_q.push_back({m_wb, 32'(m_w) | 32'(m_ovf)});
    end
    @(negedge clk);
    evt_valid = 1'b1; evt_src = s; evt_data = d; evt_ring = rg; evt_vmid = vm; evt_pasid = pa;
    do begin
      #2 rdy = evt_ready;
      if (!rdy) stalls++;
      @(negedge clk);
    end while (!rdy);
    evt_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic chk_irq(input string tag, input logic exp);
    @(negedge clk);
    #2 check(tag, 64'(irq), 64'(exp));
  endtask

  logic [31:0] rd;

  initial begin
    rst_n = 1'b0; evt_valid = 1'b0; evt_src = '0; evt_data = '0; evt_ring = '0;
    evt_vmid = '0; evt_pasid = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    db_valid = 1'b0; db_data = '0;
    m_base = '0; m_wb = '0; m_wb_on = 0; m_clr = 0; m_active = 0; m_ring = 0;
    m_size = 0; m_w = '0; m_r = '0; m_ovf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state (R11, R3)
    chk_irq("R3 reset irq", 1'b0);
    check("R10 reset mem_valid", 64'(mem_valid), 64'd0);
    reg_rd(3'd3, rd); check("R11 reset WPTR", 64'(rd), 64'd0);
    reg_rd(3'd0, rd); check("R11 reset CTRL", 64'(rd), 64'd0);

    // register map (R11, R9)
    reg_wr(3'd1, 32'h00AB_CDE1); m_base = 32'h00AB_CDE1;
    reg_wr(3'd4, 32'h0000_4440);
    reg_wr(3'd5, 32'h0000_01FF); m_wb = {8'hFF, 32'h0000_4440};
    reg_rd(3'd1, rd); check("R11 BASE readback", 64'(rd), 64'h00AB_CDE1);
    reg_rd(3'd5, rd); check("R9 WBHI keeps 8 bits", 64'(rd), 64'h0000_00FF);

    // ring on, irq off: discarded (R4)
    set_ctrl(1, 0, 0, 0, 0, 4);
    send(8'h11, 28'h0AAAAAA, 8'h01, 8'h02, 16'h0003);
    repeat (10) @(negedge clk);
    reg_rd(3'd3, rd); check("R4 WPTR unchanged with irq off", 64'(rd), 64'd0);
    chk_irq("R4 irq off", 1'b0);

    // normal record (R1, R2, R3)
    set_ctrl(1, 1, 0, 0, 0, 4);
    send(8'h5A, 28'h1234567, 8'h0C, 8'h3D, 16'hBEEF);
    drain();
    reg_rd(3'd3, rd); check("R1 WPTR after one record", 64'(rd), 64'd16);
    chk_irq("R3 irq with unread record", 1'b1);
    reg_wr(3'd2, 32'h0000_0013); m_r = 10'd16;
    reg_rd(3'd2, rd); check("R8 register RPTR write aligned", 64'(rd), 64'd16);
    chk_irq("R3 irq idle when pointers equal", 1'b0);

    // burst under back-pressure with writeback, wrap and overflow (R1, R6, R9, R10)
    set_ctrl(1, 1, 0, 1, 0, 4);
    stall_mode = 1'b1;
    stalls = 0;
    send(8'hA1, 28'h0000001, 8'h10, 8'h20, 16'h0030);
    send(8'hA2, 28'h0000002, 8'h11, 8'h21, 16'h0031);
    send(8'hA3, 28'h0000003, 8'h12, 8'h22, 16'h0032);
    send(8'hA4, 28'h0000004, 8'h13, 8'h23, 16'h0033);
    drain();
    stall_mode = 1'b0;
    check("R10 evt_ready dropped on full FIFO", 64'(stalls > 0), 64'd1);
    reg_rd(3'd3, rd); check("R6 WPTR wrapped with overflow flag", 64'(rd), 64'h11);
    chk_irq("R3 irq from overflow flag with equal pointers", 1'b1);

    // overflow clear held (R7)
    set_ctrl(1, 1, 1, 0, 0, 4);
    reg_rd(3'd3, rd); check("R7 flag cleared", 64'(rd), 64'h10);
    reg_wr(3'd2, 32'd32); m_r = 10'd32;
    send(8'hB1, 28'h0FFFFFF, 8'hFF, 8'hEE, 16'hDDDD);
    drain();
    reg_rd(3'd3, rd); check("R7 no overflow recorded while clear held", 64'(rd), 64'h20);
    set_ctrl(1, 1, 0, 0, 0, 4);
    reg_wr(3'd2, 32'd48); m_r = 10'd48;
    send(8'hB2, 28'h0000ABC, 8'h01, 8'h01, 16'h0101);
    drain();
    reg_rd(3'd3, rd); check("R7 new overflow after clear released", 64'(rd), 64'h31);

    // read-pointer paths (R8)
    set_ctrl(1, 1, 0, 0, 1, 4);
    reg_wr(3'd2, 32'd16);
    reg_rd(3'd2, rd); check("R8 register write ignored in doorbell mode", 64'(rd), 64'd48);
    @(negedge clk); db_valid = 1'b1; db_data = 32'h0000_03A5;
    @(negedge clk); db_valid = 1'b0; m_r = 10'h20;
    reg_rd(3'd2, rd); check("R8 doorbell write masked", 64'(rd), 64'h20);
    set_ctrl(1, 1, 0, 0, 0, 4);
    @(negedge clk); db_valid = 1'b1; db_data = 32'h0000_0010;
    @(negedge clk); db_valid = 1'b0;
    reg_rd(3'd2, rd); check("R8 doorbell ignored in register mode", 64'(rd), 64'h20);

    // disable clears pointers (R5), events then discarded (R4)
    set_ctrl(0, 0, 1, 0, 0, 4);
    reg_rd(3'd3, rd); check("R5 WPTR cleared", 64'(rd), 64'd0);
    reg_rd(3'd2, rd); check("R5 RPTR cleared", 64'(rd), 64'd0);
    chk_irq("R5 irq low when disabled", 1'b0);
    send(8'hC1, 28'h0000C1C, 8'h0, 8'h0, 16'h0);
    repeat (10) @(negedge clk);
    reg_rd(3'd3, rd); check("R4 WPTR unchanged with ring off", 64'(rd), 64'd0);

    // small 32-byte ring (R1, R6)
    set_ctrl(1, 1, 0, 0, 0, 3);
    send(8'hD1, 28'h0D1D1D1, 8'h07, 8'h08, 16'h0909);
    drain();
    reg_rd(3'd3, rd); check("R1 small ring step", 64'(rd), 64'd16);
    send(8'hD2, 28'h0D2D2D2, 8'h0A, 8'h0B, 16'h0C0C);
    drain();
    reg_rd(3'd3, rd); check("R6 small ring overflow wraps to zero", 64'(rd), 64'h01);
    chk_irq("R3 irq after small ring overflow", 1'b1);
    check("R10 scoreboard empty", 64'(exp_q.size()), 64'd0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule